// File: doc/BRIEF.md
# Radix-N Nibble Arithmetic Unit

This block does one-digit arithmetic on 4-bit values in a radix chosen by each instruction. The radix can be any integer from 1 to 16. The unit supports four operations:

- add with carry
- subtract with borrow
- increment by one
- decrement by one

Each result is folded back into the range of the chosen radix. The unit also reports a carry or borrow and a zero indication. A multi-digit decimal, octal or other-radix counter is built by chaining these digit operations through the carry.

The radix arrives as the raw 4-bit field taken from the instruction word. Its meaning depends on the operation:

- For add and increment the field holds the complement of the radix.
- For subtract and decrement it holds the radix itself.
- In both cases a field of zero stands for radix 16.

A `dropB` input replaces the second operand with zero for add and subtract. Only the incoming carry or borrow is then applied, which ripples it into the next digit.

The arithmetic is purely combinational. The carry and zero outputs can optionally be captured in flag registers for the following instruction.

Top module: `radix_nibble_alu`

## Requirements
- R1: With `opSel`=00 (add), `result` is `opA+opB+carryIn` reduced by the radix n when that sum is at least n. `carryOut` is 1 exactly when the reduction happened.
- R2: With `opSel`=01 (subtract), `result` is `opA-opB-carryIn`, raised by n when that difference is negative. `carryOut` (borrow) is 1 exactly when the raise happened.
- R3: With `opSel`=10 (increment), `result` is `opA+1` in radix n. `carryOut` is 1 only when `opA` equals n-1. `opB`, `carryIn` and `dropB` have no effect.
- R4: With `opSel`=11 (decrement), `result` is `opA-1` in radix n. `carryOut` is 1 only when `opA` is 0. `opB`, `carryIn` and `dropB` have no effect.
- R5: With `dropB`=1 and `opSel` 00 or 01, `opB` is replaced by zero, so only `carryIn` is added or subtracted in radix n.
- R6: For `opSel` 00 and 10, the radix is n = 16 - `radixField`, and a field of 0 gives n = 16.
- R7: For `opSel` 01 and 11, the radix is n = `radixField`, and a field of 0 gives n = 16.
- R8: `zeroOut` is 1 exactly when `result` is 0.
- R9: With `REG_FLAGS`=1, `flagC` and `flagZ` are 0 while `rstN` is low. After each rising clock edge out of reset they hold the `carryOut` and `zeroOut` present before that edge.
- R10: When every used operand is below n, `result` is below n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag registers |
| rstN | input | 1 | Active-low asynchronous reset of the flag registers |
| opSel | input | 2 | Operation: 00 add, 01 subtract, 10 increment, 11 decrement |
| dropB | input | 1 | Use zero in place of `opB` for add and subtract |
| radixField | input | 4 | Raw radix field from the instruction word |
| opA | input | 4 | First operand |
| opB | input | 4 | Second operand |
| carryIn | input | 1 | Incoming carry (add) or borrow (subtract) |
| result | output | 4 | Radix-adjusted digit |
| carryOut | output | 1 | Outgoing carry or borrow |
| zeroOut | output | 1 | High when `result` is zero |
| flagC | output | 1 | Carry flag (registered when `REG_FLAGS`=1) |
| flagZ | output | 1 | Zero flag (registered when `REG_FLAGS`=1) |

## Verification
The arithmetic properties assume that `opA`, and `opB` whenever it is used, are below the radix decoded for the current operation. Outside that range the result is undefined, so each such property is gated on an in-range condition that the checker computes from the ports.

The sweeps for add and subtract cover every radix from 1 to 16. For each radix they draw both operands from 0 to n-1, with both carry values.

The increment, decrement and zero-operand sweeps keep `opA` in range. They deliberately drive `opB` to 15, an out-of-range value, because it must be ignored there.

// File: rtl/radix_nibble_pkg.sv
package radix_nibble_pkg;
  localparam int DIGIT_W   = 4;
  localparam int RADIX_W   = DIGIT_W + 1;
  localparam int MAX_RADIX = 1 << DIGIT_W;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_INC = 2'b10,
    OP_DEC = 2'b11
  } nib_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic               subMode;   // subtract direction
    logic               unitStep;  // second operand forced to 1, carry ignored
    logic               maskB;     // second operand forced to 0
    logic [RADIX_W-1:0] radix;     // decoded radix, 1..MAX_RADIX
  } nib_ctrl_t;
endpackage

// File: rtl/radix_nibble_ctrl.sv
module radix_nibble_ctrl
  import radix_nibble_pkg::*;
(
  input  logic [1:0]         opSel,
  input  logic               dropB,
  input  logic [DIGIT_W-1:0] radixField,
  output nib_ctrl_t          ctrl
);
  logic [RADIX_W-1:0] fieldExt;

  assign fieldExt = {1'b0, radixField};

  always_comb begin
    ctrl.subMode  = opSel[0];
    ctrl.unitStep = opSel[1];
    ctrl.maskB    = dropB & ~opSel[1];
    if (radixField == '0)
      ctrl.radix = RADIX_W'(MAX_RADIX);
    else if (opSel[0])
      ctrl.radix = fieldExt;
    else
      ctrl.radix = RADIX_W'(MAX_RADIX) - fieldExt;
  end
endmodule

// File: rtl/radix_nibble_dpath.sv
module radix_nibble_dpath
  import radix_nibble_pkg::*;
(
  input  nib_ctrl_t          ctrl,
  input  logic [DIGIT_W-1:0] opA,
  input  logic [DIGIT_W-1:0] opB,
  input  logic               carryIn,
  output logic [DIGIT_W-1:0] result,
  output logic               carryOut,
  output logic               zeroOut
);
  localparam int EXT_W = DIGIT_W + 2;

  logic [DIGIT_W-1:0] secondOp;
  logic               carryUse;
  logic [EXT_W-1:0]   aExt, bExt, cExt, radixExt;
  logic [EXT_W-1:0]   addRaw, subRaw;
  logic               addWrap, subWrap;

  always_comb begin
    if (ctrl.unitStep)   secondOp = DIGIT_W'(1);
    else if (ctrl.maskB) secondOp = '0;
    else                 secondOp = opB;
  end

  assign carryUse = carryIn & ~ctrl.unitStep;
  assign aExt     = {2'b00, opA};
  assign bExt     = {2'b00, secondOp};
  assign cExt     = EXT_W'(carryUse);
  assign radixExt = {1'b0, ctrl.radix};

  assign addRaw  = aExt + bExt + cExt;
  assign subRaw  = aExt - bExt - cExt;
  assign addWrap = (addRaw >= radixExt);
  assign subWrap = subRaw[EXT_W-1];

  always_comb begin
    if (ctrl.subMode) begin
      carryOut = subWrap;
      result   = DIGIT_W'(subWrap ? subRaw + radixExt : subRaw);
    end else begin
      carryOut = addWrap;
      result   = DIGIT_W'(addWrap ? addRaw - radixExt : addRaw);
    end
  end

  assign zeroOut = (result == '0);
endmodule

// File: rtl/radix_nibble_alu.sv
module radix_nibble_alu
  import radix_nibble_pkg::*;
#(
  parameter bit REG_FLAGS = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         opSel,
  input  logic               dropB,
  input  logic [DIGIT_W-1:0] radixField,
  input  logic [DIGIT_W-1:0] opA,
  input  logic [DIGIT_W-1:0] opB,
  input  logic               carryIn,
  output logic [DIGIT_W-1:0] result,
  output logic               carryOut,
  output logic               zeroOut,
  output logic               flagC,
  output logic               flagZ
);
  nib_ctrl_t ctrl;

  radix_nibble_ctrl u_ctrl (
    .opSel      (opSel),
    .dropB      (dropB),
    .radixField (radixField),
    .ctrl       (ctrl)
  );

  radix_nibble_dpath u_dpath (
    .ctrl     (ctrl),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .result   (result),
    .carryOut (carryOut),
    .zeroOut  (zeroOut)
  );

  generate
    if (REG_FLAGS) begin : g_regFlags
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          flagC <= 1'b0;
          flagZ <= 1'b0;
        end else begin
          flagC <= carryOut;
          flagZ <= zeroOut;
        end
      end
    end else begin : g_combFlags
      assign flagC = carryOut;
      assign flagZ = zeroOut;
    end
  endgenerate
endmodule

// File: rtl/radix_nibble_alu_chk.sv
module radix_nibble_alu_chk
  import radix_nibble_pkg::*;
#(
  parameter bit REG_FLAGS = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         opSel,
  input logic               dropB,
  input logic [DIGIT_W-1:0] radixField,
  input logic [DIGIT_W-1:0] opA,
  input logic [DIGIT_W-1:0] opB,
  input logic               carryIn,
  input logic [DIGIT_W-1:0] result,
  input logic               carryOut,
  input logic               zeroOut,
  input logic               flagC,
  input logic               flagZ
);
  int  nRef, effB, effC, lhsAdd, lhsSub;
  logic inRange;

  always_comb begin
    if (radixField == '0)                 nRef = MAX_RADIX;
    else if (opSel[0])                    nRef = int'(radixField);
    else                                  nRef = MAX_RADIX - int'(radixField);
    effB    = opSel[1] ? 1 : (dropB ? 0 : int'(opB));
    effC    = opSel[1] ? 0 : int'(carryIn);
    inRange = (int'(opA) < nRef) && (opSel[1] || dropB || int'(opB) < nRef);
    lhsAdd  = int'(result) + (carryOut ? nRef : 0);
    lhsSub  = int'(result) - (carryOut ? nRef : 0);
  end

  // R1, R3, R5, R6: add-direction value identity
  p_add_sum_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!opSel[0] && inRange) |-> lhsAdd == int'(opA) + effB + effC);

  // R2, R4, R5, R7: subtract-direction value identity
  p_sub_diff_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opSel[0] && inRange) |-> lhsSub == int'(opA) - effB - effC);

  p_inc_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 2'b10 && inRange) |-> carryOut == (int'(opA) == nRef - 1));

  p_dec_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 2'b11 && inRange) |-> carryOut == (opA == '0));

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    zeroOut == (result == '0));

  p_result_below_radix_r10: assert property (@(posedge clk) disable iff (!rstN)
    inRange |-> int'(result) < nRef);

  generate
    if (REG_FLAGS) begin : g_flagChk
      p_flag_capture_r9: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) |-> (flagC == $past(carryOut)) && (flagZ == $past(zeroOut)));
    end
  endgenerate
endmodule

bind radix_nibble_alu radix_nibble_alu_chk #(.REG_FLAGS(REG_FLAGS)) u_chk (
  .clk(clk), .rstN(rstN), .opSel(opSel), .dropB(dropB), .radixField(radixField),
  .opA(opA), .opB(opB), .carryIn(carryIn), .result(result), .carryOut(carryOut),
  .zeroOut(zeroOut), .flagC(flagC), .flagZ(flagZ)
);

// File: tb/sim_radix_nibble_alu.sv
module sim_radix_nibble_alu;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] opSel = 2'b00;
  logic       dropB = 1'b0;
  logic [3:0] radixField = 4'd0;
  logic [3:0] opA = 4'd0;
  logic [3:0] opB = 4'd0;
  logic       carryIn = 1'b0;
  logic [3:0] result;
  logic       carryOut, zeroOut, flagC, flagZ;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  radix_nibble_alu #(.REG_FLAGS(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .opSel(opSel), .dropB(dropB), .radixField(radixField),
    .opA(opA), .opB(opB), .carryIn(carryIn), .result(result), .carryOut(carryOut),
    .zeroOut(zeroOut), .flagC(flagC), .flagZ(flagZ)
  );

  function automatic int fieldFor(input int op, input int n);
    if (op == 0 || op == 2) return (16 - n) % 16;
    return n % 16;
  endfunction

  function automatic void refModel(input int op, input int a, input int b, input int c,
                                   input int zb, input int n,
                                   output int res, output int cout);
    int v;
    case (op)
      0: v = a + (zb != 0 ? 0 : b) + c;
      1: v = a - (zb != 0 ? 0 : b) - c;
      2: v = a + 1;
      default: v = a - 1;
    endcase
    if (op == 0 || op == 2) begin
      cout = (v >= n) ? 1 : 0;
      res  = (v >= n) ? v - n : v;
    end else begin
      cout = (v < 0) ? 1 : 0;
      res  = (v < 0) ? v + n : v;
    end
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runVec(input string tag, input int op, input int a, input int b,
                        input int c, input int zb, input int n);
    int er, ec;
    @(negedge clk);
    opSel = 2'(op); opA = 4'(a); opB = 4'(b); carryIn = 1'(c); dropB = 1'(zb);
    radixField = 4'(fieldFor(op, n));
    #1;
    refModel(op, a, b, c, zb, n, er, ec);
    check({tag, " result"}, int'(result), er);
    check({tag, " carry"}, int'(carryOut), ec);
    check("R8 zero flag", int'(zeroOut), (er == 0) ? 1 : 0);
    check("R10 result below radix", (int'(result) < n) ? 1 : 0, 1);
  endtask

  task automatic testReset();
    #1;
    check("R9 flagC in reset", int'(flagC), 0);
    check("R9 flagZ in reset", int'(flagZ), 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testAddSweep();
    for (int n = 1; n <= 16; n++)
      for (int a = 0; a < n; a++)
        for (int b = 0; b < n; b++)
          for (int c = 0; c < 2; c++)
            runVec("R1 add", 0, a, b, c, 0, n);
  endtask

  task automatic testSubSweep();
    for (int n = 1; n <= 16; n++)
      for (int a = 0; a < n; a++)
        for (int b = 0; b < n; b++)
          for (int c = 0; c < 2; c++)
            runVec("R2 sub", 1, a, b, c, 0, n);
  endtask

  task automatic testIncDec();
    for (int n = 1; n <= 16; n++)
      for (int a = 0; a < n; a++) begin
        runVec("R3 inc", 2, a, 15, 1, 1, n);
        runVec("R4 dec", 3, a, 15, 1, 0, n);
      end
  endtask

  task automatic testZeroOperand();
    for (int n = 1; n <= 16; n++)
      for (int a = 0; a < n; a++)
        for (int c = 0; c < 2; c++) begin
          runVec("R5 add zero-B", 0, a, 15, c, 1, n);
          runVec("R5 sub zero-B", 1, a, 15, c, 1, n);
        end
  endtask

  task automatic testRadixDecode();
    // R6: add field 0 is radix 16: 9+8 = 17 -> 1 carry
    @(negedge clk);
    opSel = 2'b00; dropB = 0; radixField = 4'd0; opA = 4'd9; opB = 4'd8; carryIn = 0;
    #1;
    check("R6 field0 add result", int'(result), 1);
    check("R6 field0 add carry", int'(carryOut), 1);
    // R6: field 6 is radix 10: 7+5+1 = 13 -> 3 carry
    @(negedge clk);
    radixField = 4'd6; opA = 4'd7; opB = 4'd5; carryIn = 1;
    #1;
    check("R6 decimal add result", int'(result), 3);
    check("R6 decimal add carry", int'(carryOut), 1);
    // R7: sub field 10 is radix 10: 2-7 -> 5 borrow
    @(negedge clk);
    opSel = 2'b01; radixField = 4'd10; opA = 4'd2; opB = 4'd7; carryIn = 0;
    #1;
    check("R7 decimal sub result", int'(result), 5);
    check("R7 decimal sub borrow", int'(carryOut), 1);
    // R7: sub field 0 is radix 16: 0-0-1 -> 15 borrow
    @(negedge clk);
    radixField = 4'd0; opA = 4'd0; opB = 4'd0; carryIn = 1;
    #1;
    check("R7 field0 sub result", int'(result), 15);
    check("R7 field0 sub borrow", int'(carryOut), 1);
  endtask

  task automatic testFlagRegs();
    @(negedge clk);
    opSel = 2'b00; dropB = 0; radixField = 4'd0; opA = 4'd15; opB = 4'd1; carryIn = 0;
    @(posedge clk); #1;
    check("R9 flagC captured", int'(flagC), 1);
    check("R9 flagZ captured", int'(flagZ), 1);
    @(negedge clk);
    opA = 4'd3; opB = 4'd4;
    #1;
    check("R9 flagC held before edge", int'(flagC), 1);
    check("R9 flagZ held before edge", int'(flagZ), 1);
    @(posedge clk); #1;
    check("R9 flagC updated", int'(flagC), 0);
    check("R9 flagZ updated", int'(flagZ), 0);
  endtask

  initial begin
    testReset();
    testRadixDecode();
    testFlagRegs();
    testAddSweep();
    testSubSweep();
    testIncDec();
    testZeroOperand();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule